// File: doc/BRIEF.md
# Single-Wire Clock-and-Data Sync Line Codec

This block sits on a shared open-drain line that carries the switching clock between several power converters. The line has a pull-up and is only ever pulled low, so it reads high when idle. A strap input chooses the role at reset. A master pulls the line low once per switching period and uses the length of that low pulse to carry one bit. A short pulse of about a quarter period is the plain sync mark and means bit 1. A long pulse of about three quarters of a period means bit 0.

A slave only listens. It brings the line into its fast system clock through a two-flop synchronizer. It times the gap between falling edges to recover the period and times each low pulse to decode its bit. It raises a lock flag once the period has been steady for long enough. Transmit bits enter on a valid/ready stream that is offered once per period. Decoded bits leave on a valid/ready stream whose output register holds its value under back-pressure. When a new bit arrives and the held bit has not been accepted, the new bit replaces the held bit, because the line cannot be stalled.

All timing is counted in system clock cycles. NOM_PERIOD is the nominal line period. TOL_PERMILLE sets the accepted frequency window, and its default of 50 gives the ±5 % band around nominal. MIN_P = ceil(NOM_PERIOD·1000/(1000+TOL_PERMILLE)) and MAX_P = floor(NOM_PERIOD·1000/(1000−TOL_PERMILLE)).

Top module: `sync_line_codec`

## Requirements
- R1: With strap_n high (slave), line_pull_o and tx_ready_o stay 0. With strap_n low (master), the block drives the line from the first cycle after reset.
- R2: A master starts a low pulse every NOM_PERIOD cycles. With no bit offered, each pulse lasts NOM_PERIOD/4 cycles.
- R3: tx_ready_o is high for exactly one cycle per period, on the last cycle. A bit accepted there sets the next period's pulse: tx_bit_i = 0 gives 3·NOM_PERIOD/4 cycles and tx_bit_i = 1 gives NOM_PERIOD/4 cycles. With no valid at that cycle, the next pulse is short.
- R4: A slave measures the period as the number of cycles between two detected falling edges. It emits a decoded bit only when that period lies in [MIN_P, MAX_P] and the pulse ended before the second edge.
- R5: A decoded bit is 1 when twice the low width is less than the period, and 0 otherwise. An exact half period decodes as 0.
- R6: rx_valid_o stays high until rx_ready_i is seen. A newer decoded bit replaces an unaccepted one. With rx_ready_i high and no new bit, rx_valid_o falls after one cycle.
- R7: Lock rises after LOCK_PERIODS (default 4) consecutive in-range periods, on the cycle after the strobe of the edge that completed the run. A master holds lock high.
- R8: Lock falls after DROP_PERIODS (default 2) consecutive bad periods. A single bad period followed by a good one leaves lock high.
- R9: If no falling edge arrives within MAX_P cycles of the previous edge or of the last such timeout, the slave counts one bad period, and it keeps doing so while the line stays quiet.
- R10: clk_strobe_o is a single-cycle pulse. A master raises it in the first cycle of each pulse. A slave raises it once per detected falling edge.
- R11: A line fall applied between clock edges shows on clk_strobe_o after the third following rising edge: two synchronizer stages plus one register.
- R12: During reset, line_pull_o, tx_ready_o, rx_valid_o, clk_strobe_o and lock_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_n | input | 1 | Role strap: low = master, high = slave |
| line_i | input | 1 | Level read back from the shared line |
| line_pull_o | output | 1 | 1 = pull the shared line low |
| tx_valid_i | input | 1 | Transmit bit offered |
| tx_ready_o | output | 1 | Transmit bit taken this cycle |
| tx_bit_i | input | 1 | Transmit bit (0 = long pulse) |
| rx_valid_o | output | 1 | Decoded bit available |
| rx_ready_i | input | 1 | Consumer accepts the decoded bit |
| rx_bit_o | output | 1 | Decoded bit |
| clk_strobe_o | output | 1 | One-cycle pulse per line period |
| lock_o | output | 1 | Period recovered and steady |

## Verification
The hardest state to reach is the loss of lock. Lock has to be built up first with several clean periods. Then exactly two bad periods must follow in a row, while a single bad period followed by a good one must leave lock untouched. The bench steps through these orderings one period at a time. It also reaches a timeout by simply leaving the line high, so the receiver stays quiet until it gives up twice. The decoder is swept over every low width for periods just inside and just outside the accepted window, and the expected bits are computed from the width-versus-half-period rule.

// File: rtl/sync_codec_pkg.sv
package sync_codec_pkg;
  typedef struct packed {
    logic strobe;
    logic good;
    logic bad;
    logic bit_val;
  } rx_event_t;
endpackage

// File: rtl/sync_tx_gen.sv
module sync_tx_gen #(
  parameter int NOM_PERIOD = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tx_valid,
  input  logic tx_bit,
  output logic tx_ready,
  output logic pull,
  output logic strobe
);
  localparam int PW    = $clog2(NOM_PERIOD + 1);
  localparam int SHORT = NOM_PERIOD / 4;
  localparam int LONG  = (3 * NOM_PERIOD) / 4;

  logic [PW-1:0] ph_q;
  logic          long_q;
  logic          last;

  assign last = (ph_q == PW'(NOM_PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      long_q <= 1'b0;
    end else if (!enable) begin
      ph_q   <= '0;
      long_q <= 1'b0;
    end else begin
      ph_q <= last ? '0 : ph_q + PW'(1);
      if (last) long_q <= tx_valid & ~tx_bit;
    end
  end

  assign tx_ready = enable & last;
  assign pull     = enable & (ph_q < (long_q ? PW'(LONG) : PW'(SHORT)));
  assign strobe   = enable & (ph_q == '0);
endmodule

// File: rtl/sync_rx_meas.sv
module sync_rx_meas
  import sync_codec_pkg::*;
#(
  parameter int MIN_P = 477,
  parameter int MAX_P = 526
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      line_i,
  output rx_event_t ev_q
);
  localparam int CW = $clog2(MAX_P + 2);

  logic          s1_q, s2_q, s3_q;
  logic          fall, rise, miss, in_rng;
  logic [CW-1:0] per_q, low_q, width_q;
  logic          have_ref_q, width_ok_q;
  logic [CW:0]   twice_w, per_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= line_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign fall    = s3_q & ~s2_q;
  assign rise    = ~s3_q & s2_q;
  assign in_rng  = (per_q >= CW'(MIN_P)) && (per_q <= CW'(MAX_P));
  assign miss    = ~fall && (per_q >= CW'(MAX_P));
  assign twice_w = {width_q, 1'b0};
  assign per_x   = {1'b0, per_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q      <= '0;
      low_q      <= '0;
      width_q    <= '0;
      have_ref_q <= 1'b0;
      width_ok_q <= 1'b0;
      ev_q       <= '0;
    end else if (!enable) begin
      per_q      <= '0;
      low_q      <= '0;
      width_q    <= '0;
      have_ref_q <= 1'b0;
      width_ok_q <= 1'b0;
      ev_q       <= '0;
    end else begin
      ev_q <= '0;
      if (fall) begin
        per_q       <= CW'(1);
        low_q       <= CW'(1);
        have_ref_q  <= 1'b1;
        width_ok_q  <= 1'b0;
        ev_q.strobe <= 1'b1;
        if (have_ref_q) begin
          if (width_ok_q && in_rng) begin
            ev_q.good    <= 1'b1;
            ev_q.bit_val <= (twice_w < per_x);
          end else begin
            ev_q.bad <= 1'b1;
          end
        end
      end else begin
        if (miss) begin
          per_q      <= CW'(1);
          have_ref_q <= 1'b0;
          ev_q.bad   <= 1'b1;
        end else begin
          per_q <= per_q + CW'(1);
        end
        if (!s2_q && (low_q != {CW{1'b1}})) low_q <= low_q + CW'(1);
        if (rise) begin
          width_q    <= low_q;
          width_ok_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sync_lock_track.sv
module sync_lock_track #(
  parameter int LOCK_N = 4,
  parameter int DROP_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic good,
  input  logic bad,
  output logic lock
);
  localparam int GW = $clog2(LOCK_N + 1);
  localparam int BW = $clog2(DROP_N + 1);

  logic [GW-1:0] good_q;
  logic [BW-1:0] bad_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q <= '0;
      bad_q  <= '0;
      lock   <= 1'b0;
    end else if (!enable) begin
      good_q <= '0;
      bad_q  <= '0;
      lock   <= 1'b0;
    end else if (good) begin
      bad_q <= '0;
      if (good_q != GW'(LOCK_N)) good_q <= good_q + GW'(1);
      if (good_q == GW'(LOCK_N - 1)) lock <= 1'b1;
    end else if (bad) begin
      good_q <= '0;
      if (bad_q != BW'(DROP_N)) bad_q <= bad_q + BW'(1);
      if (bad_q == BW'(DROP_N - 1)) lock <= 1'b0;
    end
  end
endmodule

// File: rtl/sync_line_codec.sv
module sync_line_codec
  import sync_codec_pkg::*;
#(
  parameter int NOM_PERIOD   = 500,
  parameter int TOL_PERMILLE = 50,
  parameter int LOCK_PERIODS = 4,
  parameter int DROP_PERIODS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_n,
  input  logic line_i,
  output logic line_pull_o,
  input  logic tx_valid_i,
  output logic tx_ready_o,
  input  logic tx_bit_i,
  output logic rx_valid_o,
  input  logic rx_ready_i,
  output logic rx_bit_o,
  output logic clk_strobe_o,
  output logic lock_o
);
  localparam int MAX_P = (NOM_PERIOD * 1000) / (1000 - TOL_PERMILLE);
  localparam int MIN_P = (NOM_PERIOD * 1000 + 1000 + TOL_PERMILLE - 1) / (1000 + TOL_PERMILLE);

  logic      master_q, slave_q;
  logic      tx_strobe, rx_lock;
  rx_event_t ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= 1'b0;
      slave_q  <= 1'b0;
    end else begin
      master_q <= ~strap_n;
      slave_q  <= strap_n;
    end
  end

  sync_tx_gen #(.NOM_PERIOD(NOM_PERIOD)) tx_i (
    .clk(clk), .rst_n(rst_n), .enable(master_q),
    .tx_valid(tx_valid_i), .tx_bit(tx_bit_i), .tx_ready(tx_ready_o),
    .pull(line_pull_o), .strobe(tx_strobe)
  );

  sync_rx_meas #(.MIN_P(MIN_P), .MAX_P(MAX_P)) meas_i (
    .clk(clk), .rst_n(rst_n), .enable(slave_q), .line_i(line_i), .ev_q(ev)
  );

  sync_lock_track #(.LOCK_N(LOCK_PERIODS), .DROP_N(DROP_PERIODS)) lock_i (
    .clk(clk), .rst_n(rst_n), .enable(slave_q),
    .good(ev.good), .bad(ev.bad), .lock(rx_lock)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid_o <= 1'b0;
      rx_bit_o   <= 1'b0;
    end else if (!slave_q) begin
      rx_valid_o <= 1'b0;
      rx_bit_o   <= 1'b0;
    end else if (ev.good) begin
      rx_valid_o <= 1'b1;
      rx_bit_o   <= ev.bit_val;
    end else if (rx_ready_i) begin
      rx_valid_o <= 1'b0;
    end
  end

  assign clk_strobe_o = tx_strobe | ev.strobe;
  assign lock_o       = master_q | rx_lock;
endmodule

// File: rtl/sync_line_codec_chk.sv
module sync_line_codec_chk (
  input logic clk,
  input logic rst_n,
  input logic strap_n,
  input logic line_pull_o,
  input logic tx_ready_o,
  input logic rx_valid_o,
  input logic rx_ready_i,
  input logic clk_strobe_o,
  input logic lock_o
);
  AST_SLAVE_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_n && $past(strap_n)) |-> !line_pull_o); // R1
  AST_SLAVE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_n && $past(strap_n)) |-> !tx_ready_o); // R1
  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready_o |=> !tx_ready_o); // R3
  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_ready_i && strap_n && $past(strap_n)) |=> rx_valid_o); // R6
  AST_LOCK_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_n && $past(strap_n) && $rose(lock_o)) |-> $past(clk_strobe_o)); // R7
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    clk_strobe_o |=> !clk_strobe_o); // R10
endmodule

bind sync_line_codec sync_line_codec_chk chk_i (
  .clk(clk), .rst_n(rst_n), .strap_n(strap_n), .line_pull_o(line_pull_o),
  .tx_ready_o(tx_ready_o), .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i),
  .clk_strobe_o(clk_strobe_o), .lock_o(lock_o)
);

// File: tb/sync_line_codec_tb_top.sv
module sync_line_codec_tb_top;
  localparam int NOM  = 40;
  localparam int TOL  = 50;
  localparam int MAXP = (NOM * 1000) / (1000 - TOL);
  localparam int MINP = (NOM * 1000 + 1000 + TOL - 1) / (1000 + TOL);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, strap_n, line_i, line_pull_o, tx_valid_i, tx_ready_o, tx_bit_i;
  logic rx_valid_o, rx_ready_i, rx_bit_o, clk_strobe_o, lock_o;
  logic line_drv = 1'b1;
  assign line_i = line_drv & ~line_pull_o;

  sync_line_codec #(.NOM_PERIOD(NOM), .TOL_PERMILLE(TOL)) dut_i (
    .clk(clk), .rst_n(rst_n), .strap_n(strap_n), .line_i(line_i),
    .line_pull_o(line_pull_o), .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o),
    .tx_bit_i(tx_bit_i), .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i),
    .rx_bit_o(rx_bit_o), .clk_strobe_o(clk_strobe_o), .lock_o(lock_o)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // decoded-bit recorder
  int got [0:511];
  int expb [0:511];
  int ng = 0;
  int ne = 0;
  bit rec_en = 1'b0;
  always @(negedge clk)
    if (rec_en && rx_valid_o && rx_ready_i) begin
      if (ng < 512) got[ng] = rx_bit_o;
      ng++;
    end

  int slave_pulls = 0;
  always @(negedge clk) if (rst_n && strap_n && line_pull_o) slave_pulls++;

  // master pulse recorder
  bit mon_m = 1'b0;
  int mw [0:63];
  int mp [0:63];
  int nmw = 0;
  int cur_w = 0;
  int since = 0;
  bit prev_pull = 1'b0;
  int strobe_mis = 0;
  always @(negedge clk)
    if (mon_m) begin
      if (clk_strobe_o != (line_pull_o && !prev_pull)) strobe_mis++;
      if (line_pull_o && !prev_pull) begin
        if (nmw > 0 && nmw <= 64) mp[nmw-1] = since;
        since = 1;
        cur_w = 1;
        nmw++;
      end else begin
        since++;
        if (line_pull_o) cur_w++;
        if (!line_pull_o && prev_pull && nmw <= 64) mw[nmw-1] = cur_w;
      end
      prev_pull = line_pull_o;
    end

  task automatic send(input int p, input int w);
    line_drv = 1'b0;
    repeat (w) @(negedge clk);
    line_drv = 1'b1;
    repeat (p - w) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int bits [0:5];
    bits = '{0, 1, 0, 0, 1, 0};
    rst_n = 1'b0; strap_n = 1'b1; tx_valid_i = 1'b0; tx_bit_i = 1'b0; rx_ready_i = 1'b1;
    repeat (5) @(negedge clk);
    chk(line_pull_o == 0, "R12 pull", line_pull_o, 0);
    chk(lock_o == 0, "R12 lock", lock_o, 0);
    chk(rx_valid_o == 0, "R12 rx_valid", rx_valid_o, 0);
    chk(clk_strobe_o == 0, "R12 strobe", clk_strobe_o, 0);
    chk(tx_ready_o == 0, "R12 tx_ready", tx_ready_o, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R11: synchronizer latency
    line_drv = 1'b0;
    @(negedge clk); chk(clk_strobe_o == 0, "R11 edge+1", clk_strobe_o, 0);
    @(negedge clk); chk(clk_strobe_o == 0, "R11 edge+2", clk_strobe_o, 0);
    @(negedge clk); chk(clk_strobe_o == 1, "R11 edge+3", clk_strobe_o, 1);
    @(negedge clk); chk(clk_strobe_o == 0, "R10 single cycle", clk_strobe_o, 0);
    repeat (6) @(negedge clk);
    line_drv = 1'b1;
    repeat (120) @(negedge clk);

    // R7: lock after four good periods
    repeat (4) send(40, 10);
    chk(lock_o == 0, "R7 three good", lock_o, 0);
    send(40, 10);
    chk(lock_o == 1, "R7 four good", lock_o, 1);

    // R8: single bad keeps lock, two drop it
    send(36, 9); send(40, 10);
    chk(lock_o == 1, "R8 one bad", lock_o, 1);
    send(40, 10); send(36, 9); send(36, 9);
    chk(lock_o == 1, "R8 one bad again", lock_o, 1);
    send(40, 10);
    chk(lock_o == 0, "R8 two bad", lock_o, 0);

    // R9: quiet line times out twice
    repeat (5) send(40, 10);
    chk(lock_o == 1, "R9 relock", lock_o, 1);
    repeat (20) @(negedge clk);
    chk(lock_o == 1, "R9 one timeout", lock_o, 1);
    repeat (50) @(negedge clk);
    chk(lock_o == 0, "R9 two timeouts", lock_o, 0);

    // R4/R5: width and period sweep
    rec_en = 1'b1;
    send(40, 10);
    expb[ne] = 1; ne++;
    for (int p = MINP - 3; p <= MAXP + 3; p++)
      for (int w = 1; w < p; w++) begin
        send(p, w);
        if (p >= MINP && p <= MAXP) begin
          expb[ne] = (2 * w < p) ? 1 : 0;
          ne++;
        end
      end
    send(40, 10);
    rec_en = 1'b0;
    chk(ng == ne, "R4 event count", ng, ne);
    for (int i = 0; i < ne && i < 512; i++)
      chk(got[i] == expb[i], "R5 decoded bit", got[i], expb[i]);

    // R6: back-pressure keeps the newest bit
    rx_ready_i = 1'b0;
    send(40, 10); send(40, 10); send(40, 30); send(40, 10);
    chk(rx_valid_o == 1, "R6 held valid", rx_valid_o, 1);
    chk(rx_bit_o == 0, "R6 newest bit", rx_bit_o, 0);
    rx_ready_i = 1'b1;
    @(negedge clk);
    chk(rx_valid_o == 0, "R6 released", rx_valid_o, 0);
    chk(slave_pulls == 0, "R1 slave silent", slave_pulls, 0);

    // master role
    rst_n = 1'b0; strap_n = 1'b0; line_drv = 1'b1;
    repeat (5) @(negedge clk);
    chk(line_pull_o == 0, "R12 master in reset", line_pull_o, 0);
    rst_n = 1'b1;
    mon_m = 1'b1;
    tx_valid_i = 1'b1;
    tx_bit_i = bits[0][0];
    for (int i = 0; i < 6; i++) begin
      do @(negedge clk); while (!tx_ready_o);
      @(negedge clk);
      if (i < 5) tx_bit_i = bits[i+1][0];
      else tx_valid_i = 1'b0;
    end
    repeat (3 * NOM) @(negedge clk);
    mon_m = 1'b0;
    chk(nmw >= 9, "R1 master drives", nmw, 9);
    chk(mw[0] == NOM / 4, "R2 idle width", mw[0], NOM / 4);
    for (int k = 0; k < 6; k++)
      chk(mw[k+1] == (bits[k] != 0 ? NOM / 4 : (3 * NOM) / 4), "R3 bit width",
          mw[k+1], (bits[k] != 0 ? NOM / 4 : (3 * NOM) / 4));
    chk(mw[7] == NOM / 4, "R3 no valid", mw[7], NOM / 4);
    chk(mw[8] == NOM / 4, "R3 no valid", mw[8], NOM / 4);
    for (int k = 0; k < 8; k++)
      chk(mp[k] == NOM, "R2 period", mp[k], NOM);
    chk(strobe_mis == 0, "R10 master strobe", strobe_mis, 0);
    chk(lock_o == 1, "R7 master lock", lock_o, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule